// File: doc/BRIEF.md
# Debug Serial Port with Programmable Baud Divisor

This block is a two-wire asynchronous serial port for a debug console. A small register port lets software set a baud divisor, pick the parity scheme and the channel mode, write bytes to send and read bytes that arrived. Each character is a low start bit, eight data bits sent least significant first, an optional parity bit and one high stop bit.

The transmit side has a holding register in front of a shift register, so software can queue the next byte while the current one is still on the line. The receive side oversamples its input at sixteen times the baud rate. It confirms a start bit in the middle of the bit, samples each later bit at its centre and reports overrun and parity errors. A local loopback mode sends the transmit stream straight into the receiver and holds the external transmit pin high.

Register addresses on `bus_addr`: 0 control (write), 1 mode, 2 divisor, 3 transmit holding (write), 4 receive holding (read), 5 status (read). Status bits: bit0 receive ready, bit1 transmit ready, bit2 overrun, bit3 parity error, bit4 transmit empty.

Top module: `dbg_uart`

## Requirements
- R1: The 16-bit divisor at address 2 sets the baud rate. A value of 0 stops the baud clock, so a started frame makes no progress. A value d of 1 or more gives a bit period of exactly 16×d clock cycles.
- R2: Each frame is a 0 start bit, then 8 data bits LSB first, then a parity bit when mode bit 2 is 0, then a 1 stop bit. Mode bits [1:0] select the parity: 00 even, 01 odd, 10 forced 0, 11 forced 1. Any mode value 1xx in bits [2:0] sends no parity bit.
- R3: A write to address 3 while transmit ready (status bit1) is 1 loads the holding register and clears ready. Ready sets again once the byte has been copied into the shift register, while that byte is still being sent.
- R4: Transmit empty (status bit4) is 1 only when the holding register is empty and no frame is shifting. After reset the status reads 0x12.
- R5: A write to address 3 while transmit ready is 0 is dropped, and the byte never appears on `txd`.
- R6: Control bit1 (transmit reset) aborts any frame, empties the holding register, drives the line high and disables the transmitter. Control bit3 enables it, and a frame starts only while it is enabled. When both bits are written together, the reset wins.
- R7: With control bit2 (receive enable) set, a received frame places its byte at address 4 and sets receive ready (status bit0). A read of address 4 clears receive ready.
- R8: A low pulse shorter than half a bit period on the receive input is not taken as a start bit.
- R9: A frame that completes while receive ready is still set sets overrun (status bit2), and the new byte replaces the old one.
- R10: A received parity bit that does not match the selected parity sets parity error (status bit3). Control bit4 clears both overrun and parity error.
- R11: Control bit0 (receive reset) clears receive ready and disables the receiver until receive enable is written again.
- R12: Channel mode 2 (mode bits [4:3]) feeds the transmit stream to the receiver and holds `txd` high. Channel modes 0, 1 and 3 use the external pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rxd | input | 1 | Serial receive input |
| txd | output | 1 | Serial transmit output |

## Verification
The assertions assume that the bus strobes are single-cycle pulses that never overlap, and that the receive input changes only on whole bit boundaries apart from deliberate short glitches. The stimulus drives every bus access from a task that raises and lowers the strobe on falling clock edges. It builds receive frames with bit lengths that are exact multiples of sixteen times the divisor. It sends a transmit byte only when the reference model shows the holding register empty, except in the case that checks dropped writes on purpose.

// File: rtl/uart_pkg.sv
// Shared constants for the debug serial port.
// Assumes an 8-bit character and a 3-bit register address space.
package uart_pkg;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_DIV  = 3'd2;
    localparam logic [2:0] A_THR  = 3'd3;
    localparam logic [2:0] A_RHR  = 3'd4;
    localparam logic [2:0] A_STAT = 3'd5;

    localparam int C_RXRST  = 0;
    localparam int C_TXRST  = 1;
    localparam int C_RXEN   = 2;
    localparam int C_TXEN   = 3;
    localparam int C_CLRERR = 4;

    localparam logic [1:0] CH_LOOP = 2'd2;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

    // Parity bit for a data word: kind 0 even, 1 odd, 2 forced 0, 3 forced 1.
    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] kind);
        case (kind)
            2'd0:    par_bit = ^d;
            2'd1:    par_bit = ~^d;
            2'd2:    par_bit = 1'b0;
            default: par_bit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
// Oversampling tick generator: one tick every DIV clocks, none when DIV is 0.
// Assumes the divisor may change at any time; the counter wraps safely.
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = (div != '0) && (cnt >= div - 1'b1);

    // Count clocks between ticks, restarting on each tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (div == '0 || tick)      cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/uart_tx.sv
// Transmit path: holding register feeding a frame shift register.
// Assumes one oversampling tick per sixteenth of a bit; a frame starts on
// the clock after the holding register fills while enabled and idle.
module uart_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          par_on,
    input  logic [1:0]    par_kind,
    input  logic          tick,
    output logic          line,
    output logic          rdy,
    output logic          empty,
    output logic          busy_o
);
    import uart_pkg::*;

    localparam int FW = DW + 3;
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FW);

    logic [DW-1:0] thr;
    logic          full;
    logic          busy;
    logic [FW-1:0] sh;
    logic [BW-1:0] bitn;
    logic [BW-1:0] last;
    logic [CW-1:0] tcnt;

    // Holding register, frame load and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            thr  <= '0;
            full <= 1'b0;
            busy <= 1'b0;
            sh   <= '1;
            bitn <= '0;
            last <= '0;
            tcnt <= '0;
        end else begin
            if (!busy && full && en) begin
                busy <= 1'b1;
                full <= 1'b0;
                tcnt <= '0;
                bitn <= '0;
                if (par_on) begin
                    sh   <= {1'b1, par_bit(thr, par_kind), thr, 1'b0};
                    last <= BW'(DW + 2);
                end else begin
                    sh   <= {2'b11, thr, 1'b0};
                    last <= BW'(DW + 1);
                end
            end else if (busy && tick) begin
                if (tcnt == CW'(OVS - 1)) begin
                    tcnt <= '0;
                    sh   <= {1'b1, sh[FW-1:1]};
                    if (bitn == last) busy <= 1'b0;
                    else              bitn <= bitn + 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
            if (wr && !full) begin
                thr  <= wdata;
                full <= 1'b1;
            end
        end
    end

    assign line   = busy ? sh[0] : 1'b1;
    assign rdy    = !full;
    assign empty  = !full && !busy;
    assign busy_o = busy;

endmodule

// File: rtl/uart_rx.sv
// Receive sampler: synchronises the input, confirms a start bit at mid-bit,
// then samples each following bit at its centre. Pulses done for one clock
// per frame with the byte on data and the parity result on perr.
// Assumes one oversampling tick per sixteenth of a bit.
module uart_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          tick,
    input  logic          line_in,
    input  logic          par_on,
    input  logic [1:0]    par_kind,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr
);
    import uart_pkg::*;

    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DW + 2);
    localparam int HALF = OVS / 2 - 1;

    logic          s1, s2;
    rx_state_e     state;
    logic [CW-1:0] scnt;
    logic [BW-1:0] bidx;
    logic [BW-1:0] stop_idx;
    logic [DW-1:0] shreg;
    logic          pbit;

    assign stop_idx = par_on ? BW'(DW + 1) : BW'(DW);
    assign data     = shreg;

    // Two-stage synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
        end
    end

    // Frame sequencing and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= RX_IDLE;
            scnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            perr  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (en && tick && !s2) begin
                        state <= RX_START;
                        scnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (scnt == CW'(HALF)) begin
                            scnt <= '0;
                            bidx <= '0;
                            state <= s2 ? RX_IDLE : RX_BITS;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (scnt == CW'(OVS - 1)) begin
                            scnt <= '0;
                            if (bidx < BW'(DW))
                                shreg <= {s2, shreg[DW-1:1]};
                            else if (bidx == BW'(DW) && par_on)
                                pbit <= s2;
                            if (bidx == stop_idx) begin
                                state <= RX_IDLE;
                                done  <= 1'b1;
                                perr  <= par_on && (pbit != par_bit(shreg, par_kind));
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dbg_uart.sv
// Debug serial port top: register port, control and status, channel mode
// routing, and the baud, transmit and receive blocks.
// Assumes single-cycle bus strobes; read data is combinational on bus_addr.
module dbg_uart #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int BUS_W  = 16,
    parameter int OVS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rxd,
    output logic             txd
);
    import uart_pkg::*;

    logic              ctrl_wr, tx_rst_w, rx_rst_w, clr_err_w, rd_rhr;
    logic              tx_en_q, rx_en_q;
    logic [2:0]        par_q;
    logic [1:0]        chm_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rbr_q;
    logic              rx_rdy_q, ovr_q, perr_q;
    logic              tick_w, txl_w, tx_rdy_w, tx_empty_w, tx_busy_w;
    logic              rx_line_w, rx_done_w, rx_perr_w;
    logic [DATA_W-1:0] rx_data_w;

    assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    assign tx_rst_w  = ctrl_wr && bus_wdata[C_TXRST];
    assign rx_rst_w  = ctrl_wr && bus_wdata[C_RXRST];
    assign clr_err_w = ctrl_wr && bus_wdata[C_CLRERR];
    assign rd_rhr    = bus_rd && (bus_addr == A_RHR);

    // Enable bits: a reset command wins over an enable in the same write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else begin
            if (tx_rst_w)                          tx_en_q <= 1'b0;
            else if (ctrl_wr && bus_wdata[C_TXEN]) tx_en_q <= 1'b1;
            if (rx_rst_w)                          rx_en_q <= 1'b0;
            else if (ctrl_wr && bus_wdata[C_RXEN]) rx_en_q <= 1'b1;
        end
    end

    // Mode and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 3'b100;
            chm_q <= 2'b00;
            div_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE) begin
                par_q <= bus_wdata[2:0];
                chm_q <= bus_wdata[4:3];
            end
            if (bus_addr == A_DIV) div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    // Receive holding register and receive status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q    <= '0;
            rx_rdy_q <= 1'b0;
            ovr_q    <= 1'b0;
            perr_q   <= 1'b0;
        end else begin
            if (rx_done_w) rbr_q <= rx_data_w;
            if (rx_rst_w)       rx_rdy_q <= 1'b0;
            else if (rx_done_w) rx_rdy_q <= 1'b1;
            else if (rd_rhr)    rx_rdy_q <= 1'b0;
            if (clr_err_w)                             ovr_q <= 1'b0;
            else if (rx_done_w && rx_rdy_q && !rd_rhr) ovr_q <= 1'b1;
            if (clr_err_w)                    perr_q <= 1'b0;
            else if (rx_done_w && rx_perr_w)  perr_q <= 1'b1;
        end
    end

    // Read data selection.
    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = BUS_W'({chm_q, par_q});
            A_DIV:   bus_rdata = BUS_W'(div_q);
            A_RHR:   bus_rdata = BUS_W'(rbr_q);
            A_STAT:  bus_rdata = BUS_W'({tx_empty_w, perr_q, ovr_q, tx_rdy_w, rx_rdy_q});
            default: bus_rdata = '0;
        endcase
    end

    assign rx_line_w = (chm_q == CH_LOOP) ? txl_w : rxd;
    assign txd       = (chm_q == CH_LOOP) ? 1'b1  : txl_w;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .tick  (tick_w)
    );

    uart_tx #(.DW(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_rst_w),
        .en       (tx_en_q),
        .wr       (bus_wr && (bus_addr == A_THR)),
        .wdata    (bus_wdata[DATA_W-1:0]),
        .par_on   (!par_q[2]),
        .par_kind (par_q[1:0]),
        .tick     (tick_w),
        .line     (txl_w),
        .rdy      (tx_rdy_w),
        .empty    (tx_empty_w),
        .busy_o   (tx_busy_w)
    );

    uart_rx #(.DW(DATA_W), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_rst_w),
        .en       (rx_en_q),
        .tick     (tick_w),
        .line_in  (rx_line_w),
        .par_on   (!par_q[2]),
        .par_kind (par_q[1:0]),
        .done     (rx_done_w),
        .data     (rx_data_w),
        .perr     (rx_perr_w)
    );

endmodule

// File: rtl/uart_chk.sv
// Property checker for dbg_uart, attached by bind below.
// Assumes single-cycle bus strobes and a synchronous active-low reset.
module uart_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic [1:0]       chm,
    input logic [DIV_W-1:0] div,
    input logic             tick,
    input logic             tx_rdy,
    input logic             tx_empty,
    input logic             tx_busy,
    input logic             tx_rst,
    input logic             rx_rdy,
    input logic             rx_done
);

    // R12
    loop_txd_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chm == 2'd2) |-> txd);

    // R1
    div_off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !tick);

    // R4
    empty_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> ($past(tx_busy) || $past(tx_rst)));

    // R3
    ready_on_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rdy) |-> (tx_busy || $past(tx_rst)));

    // R7
    rxrdy_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rdy) |-> $past(rx_done));

    // R6
    txrst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (txd && tx_empty));

endmodule

bind dbg_uart uart_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .chm      (chm_q),
    .div      (div_q),
    .tick     (tick_w),
    .tx_rdy   (tx_rdy_w),
    .tx_empty (tx_empty_w),
    .tx_busy  (tx_busy_w),
    .tx_rst   (tx_rst_w),
    .rx_rdy   (rx_rdy_q),
    .rx_done  (rx_done_w)
);

// File: tb/sim_dbg_uart.sv
// Bench for dbg_uart: behavioural transmit-line model compared every clock,
// plus directed register checks for the receiver and status flags.
`timescale 1ns/1ps
module sim_dbg_uart;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd5;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R4";

    // Reference model state
    int   m_div, m_cnt, m_bi, m_tc, m_nb;
    int   m_fb[0:10];
    logic m_txen, m_full, m_busy;
    logic [7:0] m_thr;
    logic [2:0] m_par;
    logic [1:0] m_chm;

    always #4 clk = ~clk;

    dbg_uart u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd)
    );

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] k);
        case (k)
            2'd0: return ^d;
            2'd1: return ~^d;
            2'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Model of the transmit side, advanced on each rising edge.
    always @(posedge clk) begin : model
        logic tk, ctrl, trst, ofull, obusy;
        int ncnt;
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_bi = 0; m_tc = 0; m_nb = 10;
            m_txen = 0; m_full = 0; m_busy = 0; m_thr = 0;
            m_par = 3'b100; m_chm = 2'b00;
            for (int i = 0; i < 11; i++) m_fb[i] = 1;
        end else begin
            tk   = (m_div != 0) && (m_cnt >= m_div - 1);
            ncnt = (m_div == 0 || tk) ? 0 : m_cnt + 1;
            ctrl = bus_wr && bus_addr == 3'd0;
            trst = ctrl && bus_wdata[1];
            ofull = m_full;
            obusy = m_busy;
            if (trst) begin
                m_full = 0; m_busy = 0;
            end else begin
                if (!obusy && ofull && m_txen) begin
                    m_fb[0] = 0;
                    for (int i = 0; i < 8; i++) m_fb[i+1] = m_thr[i];
                    if (!m_par[2]) begin
                        m_fb[9] = exp_par(m_thr, m_par[1:0]); m_fb[10] = 1; m_nb = 11;
                    end else begin
                        m_fb[9] = 1; m_nb = 10;
                    end
                    m_busy = 1; m_full = 0; m_bi = 0; m_tc = 0;
                end else if (obusy && tk) begin
                    if (m_tc == 15) begin
                        m_tc = 0;
                        if (m_bi == m_nb - 1) m_busy = 0;
                        else m_bi = m_bi + 1;
                    end else m_tc = m_tc + 1;
                end
                if (bus_wr && bus_addr == 3'd3 && !ofull) begin
                    m_thr = bus_wdata[7:0]; m_full = 1;
                end
            end
            if (trst) m_txen = 0;
            else if (ctrl && bus_wdata[3]) m_txen = 1;
            if (bus_wr && bus_addr == 3'd1) begin m_par = bus_wdata[2:0]; m_chm = bus_wdata[4:3]; end
            if (bus_wr && bus_addr == 3'd2) m_div = bus_wdata;
            m_cnt = ncnt;
        end
    end

    // Compare the transmit line against the model on every falling edge.
    always @(negedge clk) begin : line_cmp
        logic e;
        if (rst_n) begin
            e = (m_chm == 2'd2) ? 1'b1 : (m_busy ? m_fb[m_bi][0] : 1'b1);
            n_cmp++;
            if (txd !== e) begin
                n_bad++;
                $display("FAIL %s txd line: actual %b expected %b at cycle %0d", cur_req, txd, e, cyc);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic tx_status(input string req);
        logic [15:0] s;
        rd_reg(3'd5, s);
        check({req, " tx ready"}, int'(s[1]), int'(!m_full));
        check({req, " tx empty"}, int'(s[4]), int'(!m_full && !m_busy));
    endtask

    task automatic wait_idle();
        while (m_full || m_busy) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic with_par, input logic pb, input int bc);
        rxd = 1'b0; repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bc) @(negedge clk); end
        if (with_par) begin rxd = pb; repeat (bc) @(negedge clk); end
        rxd = 1'b1; repeat (bc) @(negedge clk);
    endtask

    initial begin
        logic [15:0] s;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset state
        rd_reg(3'd5, s);
        check("R4 reset status", int'(s), 'h12);
        check("R6 reset line", int'(txd), 1);

        // R1: divisor 0 holds the started frame
        cur_req = "R1";
        wr_reg(3'd1, 16'h0004);
        wr_reg(3'd0, 16'h0008);
        wr_reg(3'd3, 16'h0055);
        repeat (300) @(negedge clk);
        check("R1 frame frozen with divisor 0", int'(txd), 0);
        tx_status("R1");
        wr_reg(3'd2, 16'd1);
        wait_idle();
        // R1: bit period is 16 x divisor
        wr_reg(3'd2, 16'd3);
        wr_reg(3'd3, 16'h000F);
        while (!m_busy) @(negedge clk);
        while (txd == 1'b0) @(negedge clk);
        n = 0;
        while (txd == 1'b1) begin n++; @(negedge clk); end
        check("R1 four-bit run length at divisor 3", n, 192);
        wait_idle();

        // R3: queue next byte while shifting
        cur_req = "R3";
        wr_reg(3'd2, 16'd1);
        wr_reg(3'd3, 16'h00A5);
        tx_status("R3 after first write");
        while (m_full) @(negedge clk);
        tx_status("R3 copied while shifting");
        check("R3 shifting after copy", int'(m_busy), 1);
        wr_reg(3'd3, 16'h003C);
        tx_status("R3 second queued");
        // R5: write while full is dropped
        cur_req = "R5";
        wr_reg(3'd3, 16'h00FF);
        tx_status("R5 dropped write");
        wait_idle();
        tx_status("R4 idle after frames");

        // R2: each parity choice
        cur_req = "R2";
        wr_reg(3'd2, 16'd2);
        for (int k = 0; k < 4; k++) begin
            wr_reg(3'd1, 16'(k));
            wr_reg(3'd3, 16'h00B4);
            wait_idle();
            wr_reg(3'd3, 16'h0007);
            wait_idle();
        end

        // R6: reset wins over enable; disabled transmitter holds the byte
        cur_req = "R6";
        wr_reg(3'd1, 16'h0004);
        wr_reg(3'd0, 16'h000A);
        wr_reg(3'd3, 16'h0081);
        repeat (100) @(negedge clk);
        tx_status("R6 disabled holds byte");
        rd_reg(3'd5, s);
        check("R6 held byte not started", int'(s[4]), 0);
        wr_reg(3'd0, 16'h0008);
        repeat (50) @(negedge clk);
        wr_reg(3'd0, 16'h0002);
        check("R6 line high after abort", int'(txd), 1);
        tx_status("R6 after abort");
        wr_reg(3'd0, 16'h0008);

        // R12: loopback, then other channel modes use pins
        cur_req = "R12";
        wr_reg(3'd2, 16'd1);
        wr_reg(3'd1, 16'h0014);
        wr_reg(3'd0, 16'h000C);
        wr_reg(3'd3, 16'h005A);
        wait_idle();
        repeat (40) @(negedge clk);
        rd_reg(3'd5, s);
        check("R12 R7 loopback receive ready", int'(s[0]), 1);
        rd_reg(3'd4, s);
        check("R12 loopback byte", int'(s[7:0]), 'h5A);
        rd_reg(3'd5, s);
        check("R7 ready cleared by read", int'(s[0]), 0);
        wr_reg(3'd1, 16'h001C);
        wr_reg(3'd3, 16'h0033);
        wait_idle();
        rd_reg(3'd5, s);
        check("R12 mode 3 does not loop back", int'(s[0]), 0);

        // R7, R10: external receive with parity
        cur_req = "R10";
        wr_reg(3'd1, 16'h0000);
        wr_reg(3'd2, 16'd2);
        send_rx(8'h96, 1'b1, exp_par(8'h96, 2'd0), 32);
        rd_reg(3'd5, s);
        check("R7 external frame ready", int'(s[0]), 1);
        check("R10 good even parity", int'(s[3]), 0);
        rd_reg(3'd4, s);
        check("R7 external byte", int'(s[7:0]), 'h96);
        send_rx(8'h4B, 1'b1, ~exp_par(8'h4B, 2'd0), 32);
        rd_reg(3'd5, s);
        check("R10 bad parity flagged", int'(s[3]), 1);
        rd_reg(3'd4, s);
        wr_reg(3'd0, 16'h0010);
        rd_reg(3'd5, s);
        check("R10 error cleared", int'(s[3]), 0);
        wr_reg(3'd1, 16'h0001);
        send_rx(8'h4B, 1'b1, exp_par(8'h4B, 2'd1), 32);
        rd_reg(3'd5, s);
        check("R10 good odd parity", int'(s[3]), 0);
        rd_reg(3'd4, s);
        check("R10 odd frame byte", int'(s[7:0]), 'h4B);

        // R9: overrun
        wr_reg(3'd1, 16'h0004);
        send_rx(8'h11, 1'b0, 1'b0, 32);
        send_rx(8'h22, 1'b0, 1'b0, 32);
        rd_reg(3'd5, s);
        check("R9 overrun flagged", int'(s[2]), 1);
        rd_reg(3'd4, s);
        check("R9 newer byte kept", int'(s[7:0]), 'h22);
        wr_reg(3'd0, 16'h0010);
        rd_reg(3'd5, s);
        check("R9 overrun cleared", int'(s[2]), 0);

        // R8: short glitch rejected
        rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
        repeat (400) @(negedge clk);
        rd_reg(3'd5, s);
        check("R8 glitch not received", int'(s[0]), 0);

        // R11: receive reset clears ready and disables
        send_rx(8'h77, 1'b0, 1'b0, 32);
        wr_reg(3'd0, 16'h0001);
        rd_reg(3'd5, s);
        check("R11 ready cleared", int'(s[0]), 0);
        send_rx(8'h88, 1'b0, 1'b0, 32);
        rd_reg(3'd5, s);
        check("R11 disabled receiver ignores frame", int'(s[0]), 0);
        wr_reg(3'd0, 16'h0004);
        send_rx(8'h99, 1'b0, 1'b0, 32);
        rd_reg(3'd4, s);
        check("R11 re-enabled receive byte", int'(s[7:0]), 'h99);

        repeat (10) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule